// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Controller

This block sits between the address decoder and a memory's active-low chip-enable. It stops writes that could corrupt the memory while the system is in reset. In normal running the decoded enable passes straight through.

When a supply-fall or watchdog reset begins, an access already under way is allowed to finish. The gate closes when the enable rises or when a fixed grace window runs out, whichever happens first. Once closed, the output is held at the inactive high level.

A power-up reset closes the gate at once, and it stays closed whatever the input does. Battery-backup mode also closes the gate at once. The gate opens again one clock edge after reset (and battery mode) clears.

The grace window is given in nanoseconds and turned into a cycle count from the clock frequency. The count includes the cycle in which reset is first seen.

Top module: `ce_reset_gate`

## Requirements
- R1: With reset and battery mode inactive and the gate open, `mem_ce_n` equals `dec_ce_n` in the same cycle and `gate_open` is 1.
- R2: If `dec_ce_n` is high in the cycle where a non-power-up reset first asserts, the gate closes in that cycle (`gate_open`=0). Later low levels on `dec_ce_n` leave `mem_ce_n` high.
- R3: If `dec_ce_n` is low when a non-power-up reset (`rst_pwrup`=0, supply fall or watchdog alike) asserts, `mem_ce_n` keeps following `dec_ce_n` until `dec_ce_n` goes high. From then on the gate is closed.
- R4: With `dec_ce_n` held low through a non-power-up reset, the gate passes for exactly GRACE_CYC cycles, counting the assertion cycle. It then closes and `mem_ce_n` goes high. GRACE_CYC = ceil(GRACE_NS*CLK_HZ/1e9), which is 750 by default.
- R5: While `rst_act`=1 and `rst_pwrup`=1, the gate is closed and `mem_ce_n` is 1 in every cycle, whatever `dec_ce_n` does.
- R6: While `bkup_mode`=1, the gate is closed and `mem_ce_n` is 1 at once, even in the middle of a grace window.
- R7: After `rst_act` and `bkup_mode` are both low, the gate stays closed for the rest of that cycle and opens after the next rising clock edge.
- R8: Whenever `gate_open` is 0, `mem_ce_n` is 1.
- R9: After the local reset `rst_n`, the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| dec_ce_n | input | 1 | Decoded chip-enable, active low |
| rst_act | input | 1 | System reset is asserted |
| rst_pwrup | input | 1 | 1 = current reset is a power-up reset; 0 = supply fall or watchdog |
| bkup_mode | input | 1 | Battery-backup mode active |
| mem_ce_n | output | 1 | Gated chip-enable to memory, active low |
| gate_open | output | 1 | 1 when the gate passes the input |

## Verification
The hardest case to reach is a grace window that runs all the way to its end. To get there, the enable has to stay low from before reset asserts until the count expires. The bench lowers the enable, asserts a non-power-up reset on a falling edge, holds both for GRACE_CYC-1 cycles and checks that the gate is still open. One cycle later it checks that the gate has closed. A separate test starts a grace window and then raises battery mode in the middle of it, to show that the close happens at once and does not wait for the count.

// File: rtl/ce_reset_gate.sv
module ce_reset_gate #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int GRACE_NS = 15_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_ce_n,
  input  logic rst_act,
  input  logic rst_pwrup,
  input  logic bkup_mode,
  output logic mem_ce_n,
  output logic gate_open
);
  localparam longint GRACE_L   = (longint'(GRACE_NS) * CLK_HZ + 999_999_999) / 1_000_000_000;
  localparam int     GRACE_CYC = (GRACE_L < 1) ? 1 : int'(GRACE_L);
  localparam int     CW        = $clog2(GRACE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

  typedef enum logic [1:0] {OPEN, GRACE, SHUT} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  logic soft_rst;
  assign soft_rst = rst_act && !rst_pwrup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= OPEN;
      cnt <= '0;
    end else begin
      unique case (st)
        OPEN: begin
          if (bkup_mode || (rst_act && rst_pwrup)) st <= SHUT;
          else if (rst_act) begin
            if (dec_ce_n || GRACE_CYC == 1) st <= SHUT;
            else begin
              st  <= GRACE;
              cnt <= CW'(1);
            end
          end
        end
        GRACE: begin
          if (bkup_mode || (rst_act && rst_pwrup)) st <= SHUT;
          else if (!rst_act) st <= OPEN;
          else if (dec_ce_n || cnt == LAST) st <= SHUT;
          else cnt <= cnt + CW'(1);
        end
        default: begin
          if (!rst_act && !bkup_mode) st <= OPEN;
        end
      endcase
    end
  end

  assign gate_open = !bkup_mode &&
                     ((st == OPEN  && (!rst_act || (soft_rst && !dec_ce_n))) ||
                      (st == GRACE && !rst_pwrup));
  assign mem_ce_n  = gate_open ? dec_ce_n : 1'b1;

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OPEN && !rst_act && !bkup_mode) |-> (mem_ce_n == dec_ce_n));
  // R3
  grace_end_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GRACE && dec_ce_n && rst_act) |=> (st == SHUT));
  // R4
  grace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GRACE) |-> (cnt <= LAST && cnt != '0));
  // R5
  pwrup_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && rst_pwrup) |-> mem_ce_n);
  // R6
  bkup_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_mode |-> (mem_ce_n && !gate_open));
  // R7
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHUT && !rst_act && !bkup_mode) |=> (st == OPEN));
endmodule

// File: tb/ce_reset_gate_tb_top.sv
module ce_reset_gate_tb_top;
  localparam int GRACE_CYC = 750;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_ce_n = 1'b1, rst_act = 1'b0, rst_pwrup = 1'b0, bkup_mode = 1'b0;
  logic mem_ce_n, gate_open;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ce_reset_gate dut_i (
    .clk(clk), .rst_n(rst_n), .dec_ce_n(dec_ce_n), .rst_act(rst_act),
    .rst_pwrup(rst_pwrup), .bkup_mode(bkup_mode),
    .mem_ce_n(mem_ce_n), .gate_open(gate_open)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic settle;
    #2;
  endtask

  task automatic release_all;
    step();
    rst_act = 0; rst_pwrup = 0; bkup_mode = 0; dec_ce_n = 1;
    settle();
    check("R7 closed in release cycle", gate_open, 1'b0);
    step(); settle();
    check("R7 open after next edge", gate_open, 1'b1);
  endtask

  task automatic t_reset_state;
    step(); dec_ce_n = 0; settle();
    check("R9 gate open after reset", gate_open, 1'b1);
    check("R9 output follows", mem_ce_n, 1'b0);
    step(); dec_ce_n = 1;
  endtask

  task automatic t_pass;
    for (int i = 0; i < 6; i++) begin
      step(); dec_ce_n = logic'(i % 2); settle();
      check("R1 pass through", mem_ce_n, logic'(i % 2));
      check("R1 gate open", gate_open, 1'b1);
    end
  endtask

  task automatic t_high_at_reset;
    step(); dec_ce_n = 1; rst_act = 1; settle();
    check("R2 closes same cycle", gate_open, 1'b0);
    step(); dec_ce_n = 0; settle();
    check("R2 low input blocked", mem_ce_n, 1'b1);
    check("R8 closed means high", mem_ce_n, 1'b1);
    release_all();
  endtask

  task automatic t_grace_rise;
    step(); dec_ce_n = 0; rst_act = 1; settle();
    check("R3 passes at assertion", mem_ce_n, 1'b0);
    repeat (10) step();
    settle();
    check("R3 still passing in grace", mem_ce_n, 1'b0);
    dec_ce_n = 1; settle();
    check("R3 rise passes", mem_ce_n, 1'b1);
    step(); dec_ce_n = 0; settle();
    check("R3 closed after rise", mem_ce_n, 1'b1);
    check("R3 gate flag", gate_open, 1'b0);
    release_all();
  endtask

  task automatic t_grace_expire;
    step(); dec_ce_n = 0; rst_act = 1;
    repeat (GRACE_CYC - 1) step();
    settle();
    check("R4 last grace cycle open", gate_open, 1'b1);
    check("R4 last grace cycle low", mem_ce_n, 1'b0);
    step(); settle();
    check("R4 closed after window", gate_open, 1'b0);
    check("R4 output forced high", mem_ce_n, 1'b1);
    release_all();
  endtask

  task automatic t_powerup;
    step(); dec_ce_n = 0; rst_act = 1; rst_pwrup = 1; settle();
    check("R5 immediate block", mem_ce_n, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(); dec_ce_n = logic'(i % 2); settle();
      check("R5 blocked during power-up", mem_ce_n, 1'b1);
    end
    release_all();
  endtask

  task automatic t_bkup;
    step(); dec_ce_n = 0; rst_act = 1;
    repeat (5) step();
    settle();
    check("R6 grace active before backup", mem_ce_n, 1'b0);
    bkup_mode = 1; settle();
    check("R6 backup blocks at once", mem_ce_n, 1'b1);
    step(); rst_act = 0; settle();
    check("R6 backup alone keeps closed", gate_open, 1'b0);
    release_all();
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) step();
    rst_n = 1;
    t_reset_state();
    t_pass();
    t_high_at_reset();
    t_grace_rise();
    t_grace_expire();
    t_powerup();
    t_bkup();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule